// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds a small set of 64-bit control and status registers that two independent agents can reach. A maintenance port, used by service firmware, and a memory-mapped port, used by the host, each present a byte offset. The bank turns each offset into a register index. The two ports use different mappings, so the same register sits at different offsets on each side. All accesses are 8 bytes wide, and an offset that is not 8-byte aligned is rejected.

The bank holds the following registers:
- a fault register, with alias addresses that AND or OR the written data into it;
- a control register, with alias addresses that set or clear bits;
- a base-address register that only the maintenance port may write, and that drives the base value and enable bit for address decoding elsewhere in the chip;
- a masked secondary base register;
- four plain storage registers;
- a read-only interrupt status register that samples incoming status lines every cycle.

A write that is rejected, a read of an index that cannot be read, and any misaligned access each raise a one-cycle error pulse.

Each port accepts an access on valid and ready. Read data is returned one cycle later with a read-valid strobe. The maintenance port is always ready. When both ports present a write in the same cycle, the memory-mapped port is held off for that cycle and its write completes on a later cycle.

Top module: `dual_port_csr_bank`

## Requirements
- R1: On the maintenance port, the register index is the offset shifted right by 3. On the memory-mapped port, the index is (offset >> 3) + 0x0A, so memory offset 0 selects the base-address register. An access whose offset has any of bits 2:0 set is rejected: a write changes nothing, and a read returns all ones.
- R2: `mnt_ready` is always 1. A read that is accepted on a rising edge drives the port's rvalid high and presents its data after that edge. The data is the register content from before any write accepted on the same edge.
- R3: The fault register at index 0x00 takes plain writes. A write to index 0x01 ANDs the data into it. A write to index 0x02 ORs the data into it.
- R4: The control register at index 0x0E takes plain writes. A write to index 0x12 ORs the data into it. A write to index 0x13 clears every bit that is 1 in the data.
- R5: A maintenance write to index 0x0A keeps only data bits 49:20 and bit 0. `base_addr_o` shows the stored bits 49:20, with every other bit zero. `base_en_o` shows the stored bit 0.
- R6: A memory-mapped write to index 0x0A leaves the base-address register unchanged and is rejected.
- R7: A write to the secondary base register at index 0x0B keeps only data bits 49:32.
- R8: The registers at indices 0x06, 0x07, 0x0F and 0x14 store all 64 written bits.
- R9: The status register at index 0x15 reads as `stat_i` sampled at the previous clock edge, placed at bits 36:32, with all other bits zero. Writes to index 0x15 are rejected and have no effect.
- R10: Reads of any index other than 0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x14 and 0x15 return all ones and are rejected. This includes the alias indices 0x01, 0x02, 0x12 and 0x13. Writes to indices that are not listed in R3 to R9 are rejected and have no effect.
- R11: Reset clears every register to zero, except the base-address register. That register loads `DEF_BASE`, masked to bits 49:20, with bit 0 set.
- R12: When both ports present a write in the same cycle, `mem_ready` is low for that cycle and the maintenance write takes effect. The memory-mapped write completes once it is accepted later.
- R13: `err_o` is high for exactly the one cycle after an edge that accepted at least one rejected access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mnt_valid | input | 1 | Maintenance access request |
| mnt_ready | output | 1 | Maintenance port ready (constant 1) |
| mnt_write | input | 1 | Maintenance write (1) or read (0) |
| mnt_offset | input | OFS_W | Maintenance byte offset |
| mnt_wdata | input | 64 | Maintenance write data |
| mnt_rvalid | output | 1 | Maintenance read data valid |
| mnt_rdata | output | 64 | Maintenance read data |
| mem_valid | input | 1 | Memory-mapped access request |
| mem_ready | output | 1 | Memory-mapped port ready |
| mem_write | input | 1 | Memory-mapped write (1) or read (0) |
| mem_offset | input | OFS_W | Memory-mapped byte offset |
| mem_wdata | input | 64 | Memory-mapped write data |
| mem_rvalid | output | 1 | Memory-mapped read data valid |
| mem_rdata | output | 64 | Memory-mapped read data |
| stat_i | input | STAT_W | Interrupt status lines |
| base_addr_o | output | 64 | Decoded window base address |
| base_en_o | output | 1 | Decoded window enable |
| err_o | output | 1 | Rejected-access pulse |

## Verification
The bench sweeps every aligned offset on both ports, first reading and then writing each one. It checks every result against a register model built from the requirements. A wrong index bias on the memory-mapped port would move every register by some number of slots. A base-address register that accepted host writes would change the exported window.

Alias handling is checked in both directions. An alias index that read back its target register, or that stored data into a register of its own, would show up as a mismatch in the read sweep. So would an AND alias that overwrote instead of merging.

Two ordering cases are checked directly:
- Simultaneous writes. A design that dropped the stalled memory-mapped write, or let it win, would leave the wrong value behind.
- A read on the same edge as a write. A design that forwarded the new value would return it too early.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

    localparam int DW = 64;

    // register indices (post-decode)
    localparam int IX_FAULT     = 'h00;
    localparam int IX_FAULT_AND = 'h01;
    localparam int IX_FAULT_OR  = 'h02;
    localparam int IX_ACT0      = 'h06;
    localparam int IX_ACT1      = 'h07;
    localparam int IX_BASE      = 'h0A;
    localparam int IX_SBASE     = 'h0B;
    localparam int IX_CTRL      = 'h0E;
    localparam int IX_ERRMSK    = 'h0F;
    localparam int IX_CTRL_SET  = 'h12;
    localparam int IX_CTRL_CLR  = 'h13;
    localparam int IX_DMAUP     = 'h14;
    localparam int IX_STAT      = 'h15;

    // bias added to the memory-mapped index
    localparam int MEM_BIAS     = IX_BASE;

    typedef struct packed {
        logic [DW-1:0] fault;
        logic [DW-1:0] act0;
        logic [DW-1:0] act1;
        logic [DW-1:0] base;
        logic [DW-1:0] sbase;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] errmsk;
        logic [DW-1:0] dmaup;
        logic [DW-1:0] stat;
    } bank_t;

    typedef struct packed {
        bank_t         bank;
        logic          mnt_rvalid;
        logic          mem_rvalid;
        logic [DW-1:0] mnt_rdata;
        logic [DW-1:0] mem_rdata;
        logic          err;
    } state_t;

    // contiguous mask covering bits hi..lo
    function automatic logic [DW-1:0] bit_span(input int hi, input int lo);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/csr_port_decode.sv
module csr_port_decode #(
    parameter int OFS_W = 8,
    parameter int IW    = 6,
    parameter int BIAS  = 0
) (
    input  logic [OFS_W-1:0] offset,
    output logic [IW-1:0]    idx,
    output logic             aligned
);
    localparam int WORD_W = OFS_W - 3;

    logic [IW-1:0] word_idx;

    always_comb begin
        word_idx = '0;
        word_idx[WORD_W-1:0] = offset[OFS_W-1:3];
        idx      = word_idx + IW'(BIAS);
        aligned  = (offset[2:0] == 3'b000);
    end
endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
    import csr_bank_pkg::*;
#(
    parameter int IW = 6
) (
    input  bank_t         bank,
    input  logic [IW-1:0] idx,
    input  logic          aligned,
    output logic [DW-1:0] rdata,
    output logic          hit
);
    always_comb begin
        rdata = '1;
        hit   = 1'b0;
        if (aligned) begin
            hit = 1'b1;
            case (idx)
                IW'(IX_FAULT):  rdata = bank.fault;
                IW'(IX_ACT0):   rdata = bank.act0;
                IW'(IX_ACT1):   rdata = bank.act1;
                IW'(IX_BASE):   rdata = bank.base;
                IW'(IX_SBASE):  rdata = bank.sbase;
                IW'(IX_CTRL):   rdata = bank.ctrl;
                IW'(IX_ERRMSK): rdata = bank.errmsk;
                IW'(IX_DMAUP):  rdata = bank.dmaup;
                IW'(IX_STAT):   rdata = bank.stat;
                default: begin
                    rdata = '1;
                    hit   = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/csr_write_unit.sv
module csr_write_unit
    import csr_bank_pkg::*;
#(
    parameter int IW       = 6,
    parameter int BAR_HI   = 49,
    parameter int BAR_LO   = 20,
    parameter int SBAR_LO  = 32,
    parameter int STAT_W   = 5,
    parameter int STAT_LSB = 32
) (
    input  bank_t             bank_q,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic              aligned,
    input  logic              from_mem,
    input  logic [DW-1:0]     wdata,
    input  logic [STAT_W-1:0] stat_i,
    output bank_t             bank_d,
    output logic              reject
);
    localparam logic [DW-1:0] BAR_KEEP  = bit_span(BAR_HI, BAR_LO) | DW'(1);
    localparam logic [DW-1:0] SBAR_KEEP = bit_span(BAR_HI, SBAR_LO);

    always_comb begin
        bank_d      = bank_q;
        bank_d.stat = '0;
        bank_d.stat[STAT_LSB +: STAT_W] = stat_i;
        reject      = 1'b0;
        if (we) begin
            if (!aligned) begin
                reject = 1'b1;
            end else begin
                case (idx)
                    IW'(IX_FAULT):     bank_d.fault  = wdata;
                    IW'(IX_FAULT_AND): bank_d.fault  = bank_q.fault & wdata;
                    IW'(IX_FAULT_OR):  bank_d.fault  = bank_q.fault | wdata;
                    IW'(IX_ACT0):      bank_d.act0   = wdata;
                    IW'(IX_ACT1):      bank_d.act1   = wdata;
                    IW'(IX_BASE): begin
                        if (from_mem) reject = 1'b1;
                        else          bank_d.base = wdata & BAR_KEEP;
                    end
                    IW'(IX_SBASE):     bank_d.sbase  = wdata & SBAR_KEEP;
                    IW'(IX_CTRL):      bank_d.ctrl   = wdata;
                    IW'(IX_CTRL_SET):  bank_d.ctrl   = bank_q.ctrl | wdata;
                    IW'(IX_CTRL_CLR):  bank_d.ctrl   = bank_q.ctrl & ~wdata;
                    IW'(IX_ERRMSK):    bank_d.errmsk = wdata;
                    IW'(IX_DMAUP):     bank_d.dmaup  = wdata;
                    IW'(IX_STAT):      reject        = 1'b1;
                    default:           reject        = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_port_csr_bank.sv
module dual_port_csr_bank
    import csr_bank_pkg::*;
#(
    parameter int          OFS_W    = 8,
    parameter int          BAR_HI   = 49,
    parameter int          BAR_LO   = 20,
    parameter int          SBAR_LO  = 32,
    parameter int          STAT_W   = 5,
    parameter int          STAT_LSB = 32,
    parameter logic [63:0] DEF_BASE = 64'h0003_0203_0410_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mnt_valid,
    output logic              mnt_ready,
    input  logic              mnt_write,
    input  logic [OFS_W-1:0]  mnt_offset,
    input  logic [63:0]       mnt_wdata,
    output logic              mnt_rvalid,
    output logic [63:0]       mnt_rdata,
    input  logic              mem_valid,
    output logic              mem_ready,
    input  logic              mem_write,
    input  logic [OFS_W-1:0]  mem_offset,
    input  logic [63:0]       mem_wdata,
    output logic              mem_rvalid,
    output logic [63:0]       mem_rdata,
    input  logic [STAT_W-1:0] stat_i,
    output logic [63:0]       base_addr_o,
    output logic              base_en_o,
    output logic              err_o
);
    // index wide enough for the biased memory-mapped range
    localparam int IW       = OFS_W - 2;
    localparam int NPORT    = 2;
    localparam logic [DW-1:0] BAR_KEEP = bit_span(BAR_HI, BAR_LO) | DW'(1);
    localparam logic [DW-1:0] RST_BASE = (DEF_BASE & BAR_KEEP) | DW'(1);

    state_t s_d, s_q;

    logic [OFS_W-1:0] port_off [NPORT];
    logic [IW-1:0]    port_idx [NPORT];
    logic             port_aln [NPORT];
    logic [DW-1:0]    port_rd  [NPORT];
    logic             port_hit [NPORT];

    assign port_off[0] = mnt_offset;
    assign port_off[1] = mem_offset;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        csr_port_decode #(
            .OFS_W (OFS_W),
            .IW    (IW),
            .BIAS  ((p == 1) ? MEM_BIAS : 0)
        ) u_dec (
            .offset  (port_off[p]),
            .idx     (port_idx[p]),
            .aligned (port_aln[p])
        );

        csr_read_mux #(
            .IW (IW)
        ) u_rd (
            .bank    (s_q.bank),
            .idx     (port_idx[p]),
            .aligned (port_aln[p]),
            .rdata   (port_rd[p]),
            .hit     (port_hit[p])
        );
    end

    // handshake and write arbitration
    logic mnt_wr, mem_wr_req, mem_acc, mnt_acc;
    logic mnt_rd_acc, mem_rd_acc;
    logic          wr_en, wr_aln, wr_mem;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    bank_t         bank_nxt;
    logic          wr_reject;

    always_comb begin
        mnt_wr     = mnt_valid & mnt_write;
        mem_wr_req = mem_valid & mem_write;
        mem_ready  = ~(mnt_wr & mem_wr_req);
        mnt_ready  = 1'b1;
        mnt_acc    = mnt_valid & mnt_ready;
        mem_acc    = mem_valid & mem_ready;
        mnt_rd_acc = mnt_acc & ~mnt_write;
        mem_rd_acc = mem_acc & ~mem_write;

        if (mnt_wr) begin
            wr_en   = 1'b1;
            wr_idx  = port_idx[0];
            wr_aln  = port_aln[0];
            wr_mem  = 1'b0;
            wr_data = mnt_wdata;
        end else begin
            wr_en   = mem_acc & mem_write;
            wr_idx  = port_idx[1];
            wr_aln  = port_aln[1];
            wr_mem  = 1'b1;
            wr_data = mem_wdata;
        end
    end

    csr_write_unit #(
        .IW       (IW),
        .BAR_HI   (BAR_HI),
        .BAR_LO   (BAR_LO),
        .SBAR_LO  (SBAR_LO),
        .STAT_W   (STAT_W),
        .STAT_LSB (STAT_LSB)
    ) u_wr (
        .bank_q   (s_q.bank),
        .we       (wr_en),
        .idx      (wr_idx),
        .aligned  (wr_aln),
        .from_mem (wr_mem),
        .wdata    (wr_data),
        .stat_i   (stat_i),
        .bank_d   (bank_nxt),
        .reject   (wr_reject)
    );

    // next-state process
    always_comb begin
        s_d            = s_q;
        s_d.bank       = bank_nxt;
        s_d.mnt_rvalid = mnt_rd_acc;
        s_d.mem_rvalid = mem_rd_acc;
        if (mnt_rd_acc) s_d.mnt_rdata = port_rd[0];
        if (mem_rd_acc) s_d.mem_rdata = port_rd[1];
        s_d.err = wr_reject
                | (mnt_rd_acc & ~port_hit[0])
                | (mem_rd_acc & ~port_hit[1]);
    end

    // register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.bank.base <= RST_BASE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mnt_rvalid  = s_q.mnt_rvalid;
    assign mnt_rdata   = s_q.mnt_rdata;
    assign mem_rvalid  = s_q.mem_rvalid;
    assign mem_rdata   = s_q.mem_rdata;
    assign base_addr_o = s_q.bank.base & ~DW'(1);
    assign base_en_o   = s_q.bank.base[0];
    assign err_o       = s_q.err;
endmodule

// File: rtl/csr_bank_checker.sv
module csr_bank_checker #(
    parameter int OFS_W  = 8,
    parameter int BAR_HI = 49,
    parameter int BAR_LO = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mnt_valid,
    input logic             mnt_ready,
    input logic             mnt_write,
    input logic [OFS_W-1:0] mnt_offset,
    input logic             mnt_rvalid,
    input logic [63:0]      mnt_rdata,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_write,
    input logic [63:0]      base_addr_o,
    input logic             base_en_o,
    input logic             err_o
);
    localparam logic [63:0] ADDR_SPAN = ((64'd1 << (BAR_HI + 1)) - 64'd1)
                                      & ~((64'd1 << BAR_LO) - 64'd1);
    localparam logic [OFS_W-1:0] BASE_OFS = OFS_W'(8'h50);

    AST_MNT_READ_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (mnt_valid && mnt_ready && !mnt_write) |=> mnt_rvalid); // R2

    AST_MISALIGNED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (mnt_valid && mnt_ready && !mnt_write && mnt_offset[2:0] != 3'b000)
        |=> (mnt_rdata == 64'hFFFF_FFFF_FFFF_FFFF)); // R1

    AST_MEM_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mnt_valid && mnt_write && mem_valid && mem_write) |-> !mem_ready); // R12

    AST_BASE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((base_addr_o & ~ADDR_SPAN) == 64'd0)); // R5

    AST_BASE_MAINT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(mnt_valid && mnt_ready && mnt_write && mnt_offset == BASE_OFS)
        |=> ($stable(base_addr_o) && $stable(base_en_o))); // R6

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past((mnt_valid && mnt_ready) || (mem_valid && mem_ready))); // R13
endmodule

bind dual_port_csr_bank csr_bank_checker #(
    .OFS_W  (OFS_W),
    .BAR_HI (BAR_HI),
    .BAR_LO (BAR_LO)
) u_chk (.*);

// File: tb/dual_port_csr_bank_bench.sv
module dual_port_csr_bank_bench;
    localparam logic [63:0] DEFB  = 64'h0003_0203_0410_0000;
    localparam logic [63:0] BKEEP = ((64'd1 << 50) - (64'd1 << 20)) | 64'd1;
    localparam logic [63:0] SKEEP = (64'd1 << 50) - (64'd1 << 32);

    logic clk = 1'b0, rst_n = 1'b0;
    logic mnt_valid = 0, mnt_write = 0, mem_valid = 0, mem_write = 0;
    logic [7:0] mnt_offset = 0, mem_offset = 0;
    logic [63:0] mnt_wdata = 0, mem_wdata = 0;
    logic [4:0] stat_i = 0;
    logic mnt_ready, mem_ready, mnt_rvalid, mem_rvalid, base_en_o, err_o;
    logic [63:0] mnt_rdata, mem_rdata, base_addr_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [63:0] mdl [64];

    always #2.5 clk = ~clk;

    dual_port_csr_bank #(.DEF_BASE(DEFB)) u_dual_port_csr_bank (.*);

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit readable(int i);
        return i == 'h00 || i == 'h06 || i == 'h07 || i == 'h0A || i == 'h0B ||
               i == 'h0E || i == 'h0F || i == 'h14 || i == 'h15;
    endfunction

    function automatic string tag_of(int i);
        if (i <= 2) return "R3";
        if (i == 'h0E || i == 'h12 || i == 'h13) return "R4";
        if (i == 'h0A) return "R5";
        if (i == 'h0B) return "R7";
        if (i == 'h06 || i == 'h07 || i == 'h0F || i == 'h14) return "R8";
        if (i == 'h15) return "R9";
        return "R10";
    endfunction

    function automatic logic [63:0] mdl_read(int i);
        if (!readable(i)) return '1;
        if (i == 'h15) return 64'(stat_i) << 32;
        return mdl[i];
    endfunction

    // apply a write to the model; returns the expected reject flag
    function automatic bit mdl_write(int i, logic [63:0] d, bit from_mem);
        case (i)
            'h00: mdl[0] = d;
            'h01: mdl[0] = mdl[0] & d;
            'h02: mdl[0] = mdl[0] | d;
            'h06, 'h07, 'h0E, 'h0F, 'h14: mdl[i] = d;
            'h0A: begin
                if (from_mem) return 1;
                mdl[i] = d & BKEEP;
            end
            'h0B: mdl[i] = d & SKEEP;
            'h12: mdl['h0E] = mdl['h0E] | d;
            'h13: mdl['h0E] = mdl['h0E] & ~d;
            default: return 1;
        endcase
        return 0;
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        mdl['h0A] = (DEFB & BKEEP) | 64'd1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mdl_reset();
    endtask

    // single access on one port (port 0 maintenance, 1 memory-mapped)
    task automatic access(int port, bit wr, logic [7:0] off, logic [63:0] d);
        int i;
        bit aln, exp_err;
        logic [63:0] exp_rd;
        i   = int'(off >> 3) + (port == 1 ? 'h0A : 0);
        aln = (off[2:0] == 3'b000);
        exp_rd = aln ? mdl_read(i) : '1;
        @(negedge clk);
        if (port == 0) begin
            mnt_valid = 1; mnt_write = wr; mnt_offset = off; mnt_wdata = d;
        end else begin
            mem_valid = 1; mem_write = wr; mem_offset = off; mem_wdata = d;
        end
        @(negedge clk);
        mnt_valid = 0; mem_valid = 0;
        if (wr) begin
            exp_err = aln ? mdl_write(i, d, port == 1) : 1'b1;
            check(aln ? ((port == 1 && i == 'h0A) ? "R6" : tag_of(i)) : "R1",
                  $sformatf("write err p%0d off %h", port, off), 64'(err_o), 64'(exp_err));
        end else begin
            exp_err = !(aln && readable(i));
            if (port == 0) begin
                check(aln ? tag_of(i) : "R1", $sformatf("mnt read off %h", off), mnt_rdata, exp_rd);
                check("R2", "mnt rvalid", 64'(mnt_rvalid), 64'd1);
            end else begin
                check(aln ? tag_of(i) : "R1", $sformatf("mem read off %h", off), mem_rdata, exp_rd);
                check("R2", "mem rvalid", 64'(mem_rvalid), 64'd1);
            end
            check("R13", $sformatf("read err p%0d off %h", port, off), 64'(err_o), 64'(exp_err));
        end
    endtask

    task automatic sweep_read(int port);
        for (int k = 0; k < 32; k++) access(port, 0, 8'(k * 8), '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] old_ctrl;
        do_reset();
        // R11: reset state
        check("R11", "base_addr_o", base_addr_o, DEFB & BKEEP & ~64'd1);
        check("R11", "base_en_o", 64'(base_en_o), 64'd1);
        check("R13", "err after reset", 64'(err_o), 64'd0);
        check("R2", "mnt_ready", 64'(mnt_ready), 64'd1);
        sweep_read(0);
        sweep_read(1);

        // R9: status sampling
        stat_i = 5'h15;
        repeat (2) @(negedge clk);

        // maintenance write sweep, every index
        for (int k = 0; k < 32; k++)
            access(0, 1, 8'(k * 8), 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) * 64'h0101_0203_0405_0709));
        check("R5", "base_addr_o after write", base_addr_o, mdl['h0A] & ~64'd1);
        check("R5", "base_en_o after write", 64'(base_en_o), 64'(mdl['h0A][0]));
        sweep_read(0);
        sweep_read(1);

        // memory-mapped write sweep
        for (int k = 0; k < 32; k++)
            access(1, 1, 8'(k * 8), 64'h1357_9BDF_2468_ACE0 ^ (64'(k) * 64'h0011_2233_4455_6677));
        check("R6", "base_addr_o unchanged", base_addr_o, mdl['h0A] & ~64'd1);
        sweep_read(0);

        // aliases with targeted values
        access(0, 1, 8'h00, 64'hFF00_FF00_FF00_FF00);
        access(0, 1, 8'h08, 64'h0FF0_0FF0_0FF0_0FF0);
        access(0, 1, 8'h10, 64'h0000_0000_0000_0003);
        access(0, 0, 8'h00, '0);
        access(0, 1, 8'h70, 64'h0000_00FF_0000_00F0);
        access(1, 1, 8'h40, 64'h8000_0000_0000_0001);
        access(1, 1, 8'h48, 64'h0000_00F0_0000_0010);
        access(1, 0, 8'h20, '0);
        // base enable cleared, then set by maintenance port
        access(0, 1, 8'h50, 64'hFFFF_FFFF_FFFF_FFFE);
        check("R5", "base_en_o cleared", 64'(base_en_o), 64'd0);
        access(1, 1, 8'h00, 64'h0000_0000_0000_0001);
        check("R6", "base_en_o kept", 64'(base_en_o), 64'd0);

        // R1: misaligned accesses
        access(0, 1, 8'h01, 64'hDEAD_BEEF_DEAD_BEEF);
        access(0, 0, 8'h03, '0);
        access(1, 1, 8'h25, 64'hDEAD_BEEF_DEAD_BEEF);
        access(1, 0, 8'h26, '0);
        access(0, 0, 8'h00, '0);

        // R12: simultaneous writes
        @(negedge clk);
        mnt_valid = 1; mnt_write = 1; mnt_offset = 8'h90; mnt_wdata = 64'h00F0_0000_0000_0F00;
        mem_valid = 1; mem_write = 1; mem_offset = 8'h50; mem_wdata = 64'hCAFE_F00D_1234_5678;
        #1 check("R12", "mem_ready during clash", 64'(mem_ready), 64'd0);
        @(negedge clk);
        mnt_valid = 0;
        void'(mdl_write('h12, 64'h00F0_0000_0000_0F00, 0));
        #1 check("R12", "mem_ready after clash", 64'(mem_ready), 64'd1);
        @(negedge clk);
        mem_valid = 0;
        void'(mdl_write('h14, 64'hCAFE_F00D_1234_5678, 1));
        check("R13", "err after clash", 64'(err_o), 64'd0);
        access(0, 0, 8'h70, '0);
        access(0, 0, 8'hA0, '0);

        // R2: read on the same edge as a write to the same register
        old_ctrl = mdl['h0E];
        @(negedge clk);
        mnt_valid = 1; mnt_write = 0; mnt_offset = 8'h70;
        mem_valid = 1; mem_write = 1; mem_offset = 8'h20; mem_wdata = 64'h5555_AAAA_5555_AAAA;
        @(negedge clk);
        mnt_valid = 0; mem_valid = 0;
        check("R2", "read returns pre-write value", mnt_rdata, old_ctrl);
        void'(mdl_write('h0E, 64'h5555_AAAA_5555_AAAA, 1));
        access(0, 0, 8'h70, '0);

        // R9: status follows input
        stat_i = 5'h0A;
        access(1, 0, 8'h58, '0);
        access(0, 1, 8'hA8, '1);
        access(0, 0, 8'hA8, '0);

        // R11: reset again restores defaults
        do_reset();
        check("R11", "base_addr_o after reset", base_addr_o, DEFB & BKEEP & ~64'd1);
        sweep_read(0);

        finish_run();
    end
endmodule